// File: doc/BRIEF.md
# Boot configuration byte loader

This block fills an 8-bit system configuration register automatically each time the chip comes out of reset. When the active-low reset line is released, it makes one read of a fixed boot address. The read goes to one of two ports. One is the internal program memory port. The other is the external bus port. A test input pin, sampled on the first clock after reset release, chooses the port. The byte that comes back is stored in the register. Software can also write the register once the fetch has finished.

The stored byte is decoded into the system operating mode:
- the multifunction pin mode (bus or normal);
- which program store is used (internal ROM, internal test ROM or the external bus);
- the internal RAM enable;
- the internal CPU enable.

Until the fetch has completed, the decoded outputs stay in a safe state with the CPU disabled. Each handshake port has a request output and a read-data-valid input. The memories themselves live outside the block.

Top module: `boot_cfg_loader`

## Requirements
- R1: After `rst_ni` rises, exactly one read is issued, at byte address 0x00FFF3. The request stays high until the selected port returns valid, then drops and is not raised again before the next reset.
- R2: The test pin value at the first clock edge after reset release picks the port. A 0 uses the internal port (`imem_req_o`) and a 1 uses the external port (`xbus_req_o`). The other port's request stays low.
- R3: The register loads read data only on a valid pulse from the selected port while the fetch is pending. A valid on the unselected port, or any valid after the fetch has completed, leaves the register unchanged.
- R4: While reset is asserted or the fetch is pending, the outputs are in the safe state. That state is `cfg_valid_o`=0, `cpu_en_o`=0, `ram_en_o`=0, `pin_bus_mode_o`=0 and `prog_src_o`=0. The register resets to 0x00.
- R5: The decoded outputs become valid exactly one clock after the edge that captures the fetched byte.
- R6: `ram_en_o` follows bit 1 of the register and `cpu_en_o` follows bit 0 (1 = enabled).
- R7: `prog_src_o` is decoded from bits 2 and 3 of the register:
  - 2 (external) when bit 2 = 0;
  - 0 (internal ROM) when bit 2 = 1 and bit 3 = 1;
  - 1 (test ROM) when bit 2 = 1 and bit 3 = 0.
  The value 3 never appears.
- R8: `pin_bus_mode_o` is decoded from bits 4 and 6 of the register:
  - 0 (normal) when bit 4 = 1;
  - 1 (bus) when bit 4 = 0 and bit 6 = 0;
  - the inverse of the live test pin when bit 4 = 0 and bit 6 = 1, following a pin change one clock later.
- R9: Byte 0xFF decodes to normal pin mode, internal ROM, RAM on and CPU on. Byte 0xAB decodes to bus pin mode, external program store, RAM on and CPU on.
- R10: After the fetch, a software write loads the register on the next edge, and the decoded outputs follow one clock later. Software writes made while the fetch is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release starts the fetch |
| test_pin_i | input | 1 | Test pin: picks the fetch port and drives the live pin-mode toggle |
| imem_req_o | output | 1 | Read request to the internal program memory |
| imem_addr_o | output | ADDR_W | Read address to the internal program memory |
| imem_rdata_i | input | 8 | Read data from the internal program memory |
| imem_rvalid_i | input | 1 | Read data valid from the internal program memory |
| xbus_req_o | output | 1 | Read request on the external bus |
| xbus_addr_o | output | ADDR_W | Read address on the external bus |
| xbus_rdata_i | input | 8 | Read data from the external bus |
| xbus_rvalid_i | input | 1 | Read data valid from the external bus |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 8 | Software write data |
| cfg_q_o | output | 8 | Current register contents |
| cfg_valid_o | output | 1 | Decoded outputs are valid |
| pin_bus_mode_o | output | 1 | 1 = multifunction pins in bus mode, 0 = normal |
| prog_src_o | output | 2 | Program store: 0 internal ROM, 1 test ROM, 2 external |
| ram_en_o | output | 1 | Internal RAM enable |
| cpu_en_o | output | 1 | Internal CPU enable |

## Verification
The assertions check four things on every cycle. The fetch request is held until its valid arrives. A capture stores the byte from the selected port. The register does not move during the fetch unless a capture occurs. The outputs stay safe whenever the block is not running, and the program-store code never takes its unused value.

Some behaviour can only be shown by the bench scenarios. These are the port choice made by the test pin, the one-clock gap between capture and valid outputs, and the full decode tables, including the two named bytes. They also include the live pin-mode toggle and the rejection of stray valids and early software writes.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  localparam int CFG_W = 8;

  // bit positions read by the decoder
  localparam int B_TGL    = 6;
  localparam int B_PINMOD = 4;
  localparam int B_ROMSEL = 3;
  localparam int B_INTMEM = 2;
  localparam int B_RAM    = 1;
  localparam int B_CPU    = 0;

  typedef enum logic [1:0] {ST_START = 2'd0, ST_WAIT = 2'd1, ST_RUN = 2'd2} fetch_st_e;
  typedef enum logic [1:0] {SRC_IROM = 2'd0, SRC_TROM = 2'd1, SRC_EXT = 2'd2} prog_src_e;

  typedef struct packed {
    logic      bus_mode;
    prog_src_e src;
    logic      ram_en;
    logic      cpu_en;
  } sys_mode_t;

  localparam sys_mode_t SAFE_MODE = '{bus_mode: 1'b0, src: SRC_IROM, ram_en: 1'b0, cpu_en: 1'b0};

  function automatic sys_mode_t decode_cfg(input logic [CFG_W-1:0] c, input logic test);
    sys_mode_t m;
    m.cpu_en = c[B_CPU];
    m.ram_en = c[B_RAM];
    if (!c[B_INTMEM])      m.src = SRC_EXT;
    else if (c[B_ROMSEL])  m.src = SRC_IROM;
    else                   m.src = SRC_TROM;
    if (c[B_PINMOD])       m.bus_mode = 1'b0;
    else if (c[B_TGL])     m.bus_mode = ~test;
    else                   m.bus_mode = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/boot_fetch_fsm.sv
module boot_fetch_fsm
  import boot_cfg_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 24'h00FFF3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_pin_i,
  input  logic              imem_rvalid_i,
  input  logic              xbus_rvalid_i,
  output logic              imem_req_o,
  output logic              xbus_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ext_sel_o,
  output logic              capture_o,
  output logic              run_o
);
  fetch_st_e st_q;
  logic      ext_q;
  logic      pend;
  logic      rvalid_sel;

  assign pend       = (st_q == ST_WAIT);
  assign rvalid_sel = ext_q ? xbus_rvalid_i : imem_rvalid_i;
  assign capture_o  = pend && rvalid_sel;
  assign imem_req_o = pend && !ext_q;
  assign xbus_req_o = pend && ext_q;
  assign addr_o     = BOOT_ADDR;
  assign ext_sel_o  = ext_q;
  assign run_o      = (st_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_START;
      ext_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_START: begin
          ext_q <= test_pin_i;
          st_q  <= ST_WAIT;
        end
        ST_WAIT: if (rvalid_sel) st_q <= ST_RUN;
        default: st_q <= ST_RUN;
      endcase
    end
  end

  // request held until the selected port answers
  a_r1_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((imem_req_o && !imem_rvalid_i) || (xbus_req_o && !xbus_rvalid_i)) |=> (imem_req_o || xbus_req_o));
  a_r1_no_second_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> (!imem_req_o && !xbus_req_o));
endmodule

// File: rtl/boot_cfg_reg.sv
module boot_cfg_reg
  import boot_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             ext_sel_i,
  input  logic             run_i,
  input  logic [CFG_W-1:0] imem_rdata_i,
  input  logic [CFG_W-1:0] xbus_rdata_i,
  input  logic             sw_we_i,
  input  logic [CFG_W-1:0] sw_wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] fetch_data;

  assign fetch_data = ext_sel_i ? xbus_rdata_i : imem_rdata_i;
  assign cfg_o      = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cfg_q <= '0;
    else if (capture_i)        cfg_q <= fetch_data;
    else if (run_i && sw_we_i) cfg_q <= sw_wdata_i;
  end

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (cfg_o == $past(ext_sel_i ? xbus_rdata_i : imem_rdata_i)));
  a_r10_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !capture_i) |=> $stable(cfg_o));
endmodule

// File: rtl/boot_mode_dec.sv
module boot_mode_dec
  import boot_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             test_pin_i,
  output logic             valid_o,
  output logic             bus_mode_o,
  output logic [1:0]       src_o,
  output logic             ram_en_o,
  output logic             cpu_en_o
);
  sys_mode_t mode_q;
  logic      valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= SAFE_MODE;
      valid_q <= 1'b0;
    end else begin
      mode_q  <= run_i ? decode_cfg(cfg_i, test_pin_i) : SAFE_MODE;
      valid_q <= run_i;
    end
  end

  assign valid_o    = valid_q;
  assign bus_mode_o = mode_q.bus_mode;
  assign src_o      = mode_q.src;
  assign ram_en_o   = mode_q.ram_en;
  assign cpu_en_o   = mode_q.cpu_en;

  a_r4_safe_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!valid_o && !cpu_en_o && !ram_en_o && !bus_mode_o && src_o == 2'd0));
  a_r7_src_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (src_o != 2'd3));
endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
  import boot_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 24'h00FFF3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_pin_i,
  output logic              imem_req_o,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic [7:0]        imem_rdata_i,
  input  logic              imem_rvalid_i,
  output logic              xbus_req_o,
  output logic [ADDR_W-1:0] xbus_addr_o,
  input  logic [7:0]        xbus_rdata_i,
  input  logic              xbus_rvalid_i,
  input  logic              sw_we_i,
  input  logic [7:0]        sw_wdata_i,
  output logic [7:0]        cfg_q_o,
  output logic              cfg_valid_o,
  output logic              pin_bus_mode_o,
  output logic [1:0]        prog_src_o,
  output logic              ram_en_o,
  output logic              cpu_en_o
);
  logic              ext_sel, capture, run;
  logic [ADDR_W-1:0] addr;
  logic [CFG_W-1:0]  cfg;

  boot_fetch_fsm #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT_ADDR)) u_fsm (
    .clk_i, .rst_ni, .test_pin_i,
    .imem_rvalid_i, .xbus_rvalid_i,
    .imem_req_o, .xbus_req_o,
    .addr_o(addr), .ext_sel_o(ext_sel), .capture_o(capture), .run_o(run)
  );

  boot_cfg_reg u_reg (
    .clk_i, .rst_ni,
    .capture_i(capture), .ext_sel_i(ext_sel), .run_i(run),
    .imem_rdata_i, .xbus_rdata_i, .sw_we_i, .sw_wdata_i,
    .cfg_o(cfg)
  );

  boot_mode_dec u_dec (
    .clk_i, .rst_ni, .run_i(run), .cfg_i(cfg), .test_pin_i,
    .valid_o(cfg_valid_o), .bus_mode_o(pin_bus_mode_o), .src_o(prog_src_o),
    .ram_en_o, .cpu_en_o
  );

  assign imem_addr_o = addr;
  assign xbus_addr_o = addr;
  assign cfg_q_o     = cfg;
endmodule

// File: tb/sim_boot_cfg_loader.sv
module sim_boot_cfg_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        test_pin = 1'b0;
  logic        imem_req, xbus_req;
  logic [23:0] imem_addr, xbus_addr;
  logic [7:0]  imem_rdata = '0, xbus_rdata = '0;
  logic        imem_rvalid = 1'b0, xbus_rvalid = 1'b0;
  logic        sw_we = 1'b0;
  logic [7:0]  sw_wdata = '0;
  logic [7:0]  cfg_q;
  logic        cfg_valid, bus_mode, ram_en, cpu_en;
  logic [1:0]  src;

  int vec = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_ni), .test_pin_i(test_pin),
    .imem_req_o(imem_req), .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata), .imem_rvalid_i(imem_rvalid),
    .xbus_req_o(xbus_req), .xbus_addr_o(xbus_addr), .xbus_rdata_i(xbus_rdata), .xbus_rvalid_i(xbus_rvalid),
    .sw_we_i(sw_we), .sw_wdata_i(sw_wdata),
    .cfg_q_o(cfg_q), .cfg_valid_o(cfg_valid), .pin_bus_mode_o(bus_mode),
    .prog_src_o(src), .ram_en_o(ram_en), .cpu_en_o(cpu_en)
  );

  function automatic logic [1:0] exp_src(logic [7:0] c);
    if (!c[2]) return 2'd2;
    return c[3] ? 2'd0 : 2'd1;
  endfunction

  function automatic logic exp_bus(logic [7:0] c, logic t);
    if (c[4]) return 1'b0;
    return c[6] ? ~t : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_mode(input logic [7:0] c, input logic t, input string tag);
    chk(cfg_valid == 1'b1, tag, "valid", cfg_valid, 1);
    chk(ram_en == c[1], "R6", "ram_en", ram_en, c[1]);
    chk(cpu_en == c[0], "R6", "cpu_en", cpu_en, c[0]);
    chk(src == exp_src(c), "R7", "prog_src", src, exp_src(c));
    chk(bus_mode == exp_bus(c, t), "R8", "bus_mode", bus_mode, exp_bus(c, t));
  endtask

  task automatic boot(input logic [7:0] b, input logic t, input int lat, input logic [7:0] w);
    logic [7:0] junk;
    @(negedge clk);
    rst_ni = 1'b0;
    test_pin = t;
    #1;
    chk(cfg_q == 8'h00, "R4", "reset cfg", cfg_q, 0);
    chk(!cfg_valid && !cpu_en && !ram_en && !bus_mode && src == 2'd0, "R4", "reset safe",
        {cfg_valid, cpu_en, ram_en, bus_mode, src}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(imem_req == !t && xbus_req == t, "R2", "port select", {imem_req, xbus_req}, {!t, t});
    chk((t ? xbus_addr : imem_addr) == 24'h00FFF3, "R1", "boot addr", t ? xbus_addr : imem_addr, 24'h00FFF3);
    // early software write and stray valid on the other port
    junk = ~b;
    sw_we = 1'b1; sw_wdata = junk;
    if (t) begin imem_rvalid = 1'b1; imem_rdata = junk; end
    else   begin xbus_rvalid = 1'b1; xbus_rdata = junk; end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      sw_we = 1'b0; imem_rvalid = 1'b0; xbus_rvalid = 1'b0;
      chk(cfg_q == 8'h00, "R10", "write during fetch", cfg_q, 0);
      chk(cfg_q == 8'h00, "R3", "other port valid", cfg_q, 0);
      chk((imem_req || xbus_req) && !cfg_valid && !cpu_en, "R4", "pending", {imem_req, xbus_req, cfg_valid}, 3'b100);
    end
    if (t) begin xbus_rvalid = 1'b1; xbus_rdata = b; end
    else   begin imem_rvalid = 1'b1; imem_rdata = b; end
    @(negedge clk);
    imem_rvalid = 1'b0; xbus_rvalid = 1'b0;
    chk(cfg_q == b, "R3", "captured byte", cfg_q, b);
    chk(!cfg_valid, "R5", "valid too early", cfg_valid, 0);
    chk(!imem_req && !xbus_req, "R1", "req dropped", {imem_req, xbus_req}, 0);
    @(negedge clk);
    chk_mode(b, t, "R5");
    if (b == 8'hFF) chk(!bus_mode && src == 2'd0 && ram_en && cpu_en, "R9", "0xFF standalone", {bus_mode, src}, 0);
    if (b == 8'hAB) chk(bus_mode && src == 2'd2 && ram_en && cpu_en, "R9", "0xAB external", {bus_mode, src}, 3'b110);
    // stray valid after fetch
    imem_rvalid = 1'b1; xbus_rvalid = 1'b1; imem_rdata = junk; xbus_rdata = junk;
    @(negedge clk);
    imem_rvalid = 1'b0; xbus_rvalid = 1'b0;
    chk(cfg_q == b, "R3", "late valid", cfg_q, b);
    chk(!imem_req && !xbus_req, "R1", "single read", {imem_req, xbus_req}, 0);
    // live test pin toggle
    test_pin = ~t;
    @(negedge clk);
    chk(bus_mode == exp_bus(b, ~t), "R8", "live toggle", bus_mode, exp_bus(b, ~t));
    // software write
    sw_we = 1'b1; sw_wdata = w;
    @(negedge clk);
    sw_we = 1'b0;
    chk(cfg_q == w, "R10", "sw write", cfg_q, w);
    @(negedge clk);
    chk_mode(w, ~t, "R10");
  endtask

  initial begin
    void'($urandom(32'd1631));
    repeat (2) @(negedge clk);
    boot(8'hFF, 1'b0, 1, 8'hAB);
    boot(8'hAB, 1'b1, 3, 8'hFF);
    boot(8'h40, 1'b0, 2, 8'h50);
    boot(8'h44, 1'b1, 1, 8'h0C);
    for (int n = 0; n < 60; n++)
      boot(8'($urandom), 1'($urandom), 1 + int'($urandom % 5), 8'($urandom));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule